// File: doc/BRIEF.md
# Rotating-Priority Shared Bus Arbiter

This block decides which requester owns a shared external bus. Up to eight processor agents and one host each raise a request line; the arbiter grants the bus to exactly one of them at a time and reports the owner. Among the agents, priority rotates: when an agent's tenure ends, the agent just after it in numeric order becomes the most favoured, and the agent that just finished becomes the least favoured.

Three mechanisms shape tenure. An owner keeps the bus for as long as it holds its request. A fairness limit, given as a cycle count, ends an agent's tenure once it has run that many cycles while another party is waiting. A lock input, raised by the owning agent around an indivisible read-modify-write, suspends that forced release. The host is arbitrated ahead of all agents whenever the bus is free, and every change of owner passes through at least one cycle in which nobody holds a grant.

Top module: `rr_bus_arbiter`

## Requirements
- R1: After reset no grant is asserted, `owner_valid_o` is 0, `owner_id_o` is 0, and the rotation starts with agent 0 as the most favoured, so agent 0 wins when all agents request together.
- R2: At most one bit of the 9-bit vector {`host_gnt_o`, `agent_gnt_o`} is 1 in any cycle.
- R3: On a free bus, a request sampled at a clock edge produces its grant at that same edge (visible one cycle after the request is driven), and a grant is only given to an agent whose request was high at the previous edge.
- R4: Agents are searched in increasing index order starting at the most favoured index and wrapping from 7 to 0; when agent k's tenure ends, agent (k+1) mod 8 becomes the most favoured.
- R5: An owning agent keeps its grant while its request stays high (subject to R7) and its grant falls at the edge after its request falls.
- R6: When a grant falls, the following cycle has every grant low before any new grant rises.
- R7: With `fair_limit_i` = L and L not 0, an agent holding the bus while another agent or the host requests and `lock_i` is low loses the grant after exactly L grant cycles; with no one else waiting it keeps the bus past L.
- R8: `fair_limit_i` = 0 turns the fairness limit off, so contested tenures end only when the owner drops its request.
- R9: While the owning agent requests and `lock_i` is high, its grant is never taken away, whatever the fairness count or the other requests.
- R10: When the bus is free and `host_req_i` is high, the host is granted ahead of all agents; it keeps the grant until `host_req_i` falls and is not subject to the fairness limit.
- R11: A waiting host counts as a contender for the fairness limit, so it can force an agent off after L cycles.
- R12: While an agent holds the grant, `owner_id_o` carries its 3-bit index and `owner_valid_o` is 1; while the host holds it, `owner_valid_o` is 1 and `owner_id_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| agent_req_i | input | N_AGENTS | Bus request, one bit per agent |
| lock_i | input | 1 | Owner asks to keep the bus against forced release |
| host_req_i | input | 1 | Host bus request |
| fair_limit_i | input | CNT_W | Tenure limit in cycles under contention; 0 disables it |
| agent_gnt_o | output | N_AGENTS | Bus grant, one bit per agent |
| host_gnt_o | output | 1 | Host bus grant |
| owner_valid_o | output | 1 | Some party owns the bus |
| owner_id_o | output | ID_W | Index of the owning agent, 0 otherwise |

## Verification
The properties assume that `lock_i` is only meaningful while the asserting agent owns the bus and that `fair_limit_i` changes only while the bus is free, so that a tenure is measured against one fixed limit. The bench respects both: it drives requests from a model of bus agents that hold their request until they have received a given number of grant cycles, changes the limit only between scenarios once all jobs are done, and raises the lock for a whole scenario. Under those conditions every tenure has a predictable owner and length, which the scoreboard compares in order.

// File: rtl/arb_pkg.sv
package arb_pkg;

    // Who currently holds the shared bus.
    typedef enum logic [1:0] {
        BUS_FREE  = 2'd0,
        BUS_AGENT = 2'd1,
        BUS_HOST  = 2'd2
    } bus_state_e;

endpackage

// File: rtl/arb_rr_pick.sv
// Rotating search: first requesting agent at or after ptr_i, wrapping.
module arb_rr_pick #(
    parameter int N_AGENTS = 8,
    parameter int ID_W     = $clog2(N_AGENTS)
) (
    input  logic [N_AGENTS-1:0] req_i,
    input  logic [ID_W-1:0]     ptr_i,
    output logic                found_o,
    output logic [ID_W-1:0]     win_o
);

    always_comb begin
        found_o = 1'b0;
        win_o   = '0;
        // Walk from the farthest slot back to ptr_i so the nearest one wins.
        for (int i = N_AGENTS - 1; i >= 0; i--) begin
            int j;
            j = int'(ptr_i) + i;
            if (j >= N_AGENTS) begin
                j = j - N_AGENTS;
            end
            if (req_i[j]) begin
                found_o = 1'b1;
                win_o   = ID_W'(j);
            end
        end
    end

endmodule

// File: rtl/arb_tenure.sv
// Counts cycles of the current tenure and flags when the limit is reached.
module arb_tenure #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear_i,
    input  logic             adv_i,
    input  logic [CNT_W-1:0] limit_i,
    output logic             expired_o
);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clear_i) begin
            cnt_d = '0;
        end else if (adv_i && (cnt_q != {CNT_W{1'b1}})) begin
            cnt_d = cnt_q + CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    // cnt_q counts completed grant cycles minus one; limit 0 means disabled.
    assign expired_o = (limit_i != '0) && (cnt_q >= (limit_i - CNT_W'(1)));

endmodule

// File: rtl/arb_gnt_dec.sv
// Turns the registered owner index into a one-hot agent grant vector.
module arb_gnt_dec #(
    parameter int N_AGENTS = 8,
    parameter int ID_W     = $clog2(N_AGENTS)
) (
    input  logic                valid_i,
    input  logic [ID_W-1:0]     id_i,
    output logic [N_AGENTS-1:0] gnt_o
);

    for (genvar g = 0; g < N_AGENTS; g++) begin : g_bit
        assign gnt_o[g] = valid_i && (id_i == ID_W'(g));
    end

endmodule

// File: rtl/rr_bus_arbiter.sv
module rr_bus_arbiter #(
    parameter int N_AGENTS = 8,
    parameter int CNT_W    = 8,
    localparam int ID_W    = $clog2(N_AGENTS)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [N_AGENTS-1:0] agent_req_i,
    input  logic                lock_i,
    input  logic                host_req_i,
    input  logic [CNT_W-1:0]    fair_limit_i,
    output logic [N_AGENTS-1:0] agent_gnt_o,
    output logic                host_gnt_o,
    output logic                owner_valid_o,
    output logic [ID_W-1:0]     owner_id_o
);

    import arb_pkg::*;

    localparam logic [ID_W-1:0] LAST_ID = ID_W'(N_AGENTS - 1);

    typedef struct packed {
        bus_state_e      st;
        logic [ID_W-1:0] id;   // owning agent
        logic [ID_W-1:0] ptr;  // most favoured agent for the next search
    } arb_state_t;

    arb_state_t s_d, s_q;

    logic                found;
    logic [ID_W-1:0]     win_id;
    logic                expired;
    logic                ten_clear;
    logic                ten_adv;
    logic                others_wait;
    logic                agent_owns;

    arb_rr_pick #(
        .N_AGENTS (N_AGENTS),
        .ID_W     (ID_W)
    ) u_pick (
        .req_i   (agent_req_i),
        .ptr_i   (s_q.ptr),
        .found_o (found),
        .win_o   (win_id)
    );

    arb_tenure #(
        .CNT_W (CNT_W)
    ) u_tenure (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear_i   (ten_clear),
        .adv_i     (ten_adv),
        .limit_i   (fair_limit_i),
        .expired_o (expired)
    );

    assign agent_owns = (s_q.st == BUS_AGENT);

    arb_gnt_dec #(
        .N_AGENTS (N_AGENTS),
        .ID_W     (ID_W)
    ) u_dec (
        .valid_i (agent_owns),
        .id_i    (s_q.id),
        .gnt_o   (agent_gnt_o)
    );

    // Anyone other than the present owner who wants the bus.
    assign others_wait = host_req_i | (|(agent_req_i & ~agent_gnt_o));

    always_comb begin
        s_d       = s_q;
        ten_clear = 1'b0;
        ten_adv   = 1'b0;
        case (s_q.st)
            BUS_FREE: begin
                ten_clear = 1'b1;
                if (host_req_i) begin
                    s_d.st = BUS_HOST;
                end else if (found) begin
                    s_d.st = BUS_AGENT;
                    s_d.id = win_id;
                end
            end
            BUS_AGENT: begin
                if (!agent_req_i[s_q.id] || (expired && others_wait && !lock_i)) begin
                    s_d.st  = BUS_FREE;
                    s_d.ptr = (s_q.id == LAST_ID) ? '0 : s_q.id + ID_W'(1);
                end else begin
                    ten_adv = 1'b1;
                end
            end
            BUS_HOST: begin
                if (!host_req_i) begin
                    s_d.st = BUS_FREE;
                end else begin
                    ten_adv = 1'b1;
                end
            end
            default: begin
                s_d.st = BUS_FREE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{st: BUS_FREE, id: '0, ptr: '0};
        end else begin
            s_q <= s_d;
        end
    end

    assign host_gnt_o    = (s_q.st == BUS_HOST);
    assign owner_valid_o = (s_q.st != BUS_FREE);
    assign owner_id_o    = agent_owns ? s_q.id : '0;

endmodule

// File: rtl/arb_checker.sv
module arb_checker #(
    parameter int N_AGENTS = 8
) (
    input logic                clk,
    input logic                rst_n,
    input logic [N_AGENTS-1:0] agent_req_i,
    input logic                lock_i,
    input logic                host_req_i,
    input logic [N_AGENTS-1:0] agent_gnt_o,
    input logic                host_gnt_o,
    input logic                owner_valid_o
);

    logic [N_AGENTS:0] all_gnt;
    assign all_gnt = {host_gnt_o, agent_gnt_o};

    assert_single_owner_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(all_gnt));

    assert_grant_to_requester_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (agent_gnt_o & ~$past(agent_req_i)) == '0);

    assert_release_on_drop_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (|(agent_gnt_o & ~agent_req_i)) |=> (agent_gnt_o == '0));

    assert_idle_between_owners_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ((|all_gnt) && (all_gnt != $past(all_gnt))) |-> ($past(all_gnt) == '0));

    assert_lock_keeps_owner_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ((|(agent_gnt_o & agent_req_i)) && lock_i) |=> $stable(agent_gnt_o));

    assert_host_first_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!owner_valid_o && host_req_i) |=> host_gnt_o);

endmodule

bind rr_bus_arbiter arb_checker #(
    .N_AGENTS (N_AGENTS)
) u_arb_checker (
    .clk           (clk),
    .rst_n         (rst_n),
    .agent_req_i   (agent_req_i),
    .lock_i        (lock_i),
    .host_req_i    (host_req_i),
    .agent_gnt_o   (agent_gnt_o),
    .host_gnt_o    (host_gnt_o),
    .owner_valid_o (owner_valid_o)
);

// File: tb/rr_bus_arbiter_bench.sv
module rr_bus_arbiter_bench;

    localparam int N     = 8;
    localparam int CW    = 8;
    localparam int HOST  = 8;   // owner code for the host in the scoreboard

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N-1:0]  agent_req = '0;
    logic          lock = 1'b0;
    logic          host_req = 1'b0;
    logic [CW-1:0] fair_limit = '0;
    logic [N-1:0]  agent_gnt;
    logic          host_gnt;
    logic          owner_valid;
    logic [2:0]    owner_id;

    always #4 clk = ~clk;  // 125 MHz

    rr_bus_arbiter #(.N_AGENTS(N), .CNT_W(CW)) u_rr_bus_arbiter (
        .clk          (clk),
        .rst_n        (rst_n),
        .agent_req_i  (agent_req),
        .lock_i       (lock),
        .host_req_i   (host_req),
        .fair_limit_i (fair_limit),
        .agent_gnt_o  (agent_gnt),
        .host_gnt_o   (host_gnt),
        .owner_valid_o(owner_valid),
        .owner_id_o   (owner_id)
    );

    typedef struct {
        int    owner;
        int    len;
        string tag;
    } tenure_t;

    tenure_t exp_q[$];
    int      job_rem[N];
    int      host_rem = 0;
    int      n_checks = 0;
    int      n_fail = 0;
    bit      done = 1'b0;

    logic [N:0] prev_gnt = '0;
    int         run_owner = -1;
    int         run_len = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic expect_tenure(input int owner, input int len, input string tag);
        tenure_t t;
        t.owner = owner;
        t.len   = len;
        t.tag   = tag;
        exp_q.push_back(t);
    endtask

    task automatic start_agent(input int idx, input int len);
        job_rem[idx] = len;
    endtask

    task automatic wait_quiet();
        bit busy;
        busy = 1'b1;
        while (busy) begin
            @(negedge clk);
            #1;
            busy = (host_rem != 0) || ({host_gnt, agent_gnt} != '0);
            for (int i = 0; i < N; i++) begin
                if (job_rem[i] != 0) busy = 1'b1;
            end
        end
        repeat (2) @(negedge clk);
        check(exp_q.size() == 0, "R4", "tenures left unserved", exp_q.size(), 0);
        exp_q.delete();
    endtask

    // Monitor (scoreboard pop) and bus-agent model, both at the falling edge.
    always @(negedge clk) begin
        if (rst_n) begin
            logic [N:0] cur;
            cur = {host_gnt, agent_gnt};
            if (cur != prev_gnt) begin
                if (prev_gnt != '0) begin
                    if (exp_q.size() == 0) begin
                        check(1'b0, "R4", "unexpected tenure owner", run_owner, -1);
                    end else begin
                        tenure_t t;
                        t = exp_q.pop_front();
                        check(run_owner == t.owner, t.tag, "tenure owner", run_owner, t.owner);
                        check(run_len == t.len, t.tag, "tenure length", run_len, t.len);
                    end
                    check(cur == '0, "R6", "idle cycle after release", int'(cur), 0);
                end
                if (cur != '0) begin
                    check($onehot(cur), "R2", "single grant", int'(cur), 0);
                    run_len = 0;
                    if (host_gnt) begin
                        run_owner = HOST;
                        check(owner_valid && owner_id == 3'd0, "R12", "host owner report",
                              int'({owner_valid, owner_id}), 8);
                    end else begin
                        for (int i = 0; i < N; i++) begin
                            if (agent_gnt[i]) run_owner = i;
                        end
                        check(owner_valid && int'(owner_id) == run_owner, "R12",
                              "agent owner id", int'(owner_id), run_owner);
                    end
                end
            end
            if (cur != '0) run_len++;
            prev_gnt = cur;

            for (int i = 0; i < N; i++) begin
                if (agent_gnt[i] && job_rem[i] > 0) job_rem[i]--;
                agent_req[i] = (job_rem[i] > 0);
            end
            if (host_gnt && host_rem > 0) host_rem--;
            host_req = (host_rem > 0);
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < N; i++) job_rem[i] = 0;
        repeat (3) @(posedge clk);
        #2;
        // R1: reset state
        check(agent_gnt == '0 && !host_gnt, "R1", "grants after reset",
              int'({host_gnt, agent_gnt}), 0);
        check(!owner_valid && owner_id == 3'd0, "R1", "owner after reset",
              int'({owner_valid, owner_id}), 0);
        rst_n = 1'b1;

        // R1/R4: all agents together, served 0..7 in order
        @(posedge clk); #2;
        fair_limit = '0;
        for (int i = 0; i < N; i++) begin
            start_agent(i, 2);
            expect_tenure(i, 2, "R4");
        end
        @(negedge clk);
        @(negedge clk); #1;
        check(agent_gnt == 8'h01, "R3", "grant one cycle after request (agent 0 first, R1)",
              int'(agent_gnt), 1);
        wait_quiet();

        // R4: favoured index is 0 after agent 7, so 2 before 5
        @(posedge clk); #2;
        start_agent(5, 1);
        start_agent(2, 1);
        expect_tenure(2, 1, "R4");
        expect_tenure(5, 1, "R5");
        wait_quiet();

        // R4: favoured index is now 6, so 6 before 2
        @(posedge clk); #2;
        start_agent(2, 1);
        start_agent(6, 1);
        expect_tenure(6, 1, "R4");
        expect_tenure(2, 1, "R5");
        wait_quiet();

        // R7: limit 3 with two contenders; favoured index is 3
        @(posedge clk); #2;
        fair_limit = 8'd3;
        start_agent(3, 5);
        start_agent(1, 7);
        expect_tenure(3, 3, "R7");
        expect_tenure(1, 3, "R7");
        expect_tenure(3, 2, "R5");
        expect_tenure(1, 4, "R7");
        wait_quiet();

        // R9: lock keeps agent 2 past the limit of 2
        @(posedge clk); #2;
        fair_limit = 8'd2;
        lock = 1'b1;
        start_agent(2, 5);
        start_agent(3, 1);
        expect_tenure(2, 5, "R9");
        expect_tenure(3, 1, "R4");
        wait_quiet();
        lock = 1'b0;

        // R8: limit 0 disables forced release
        @(posedge clk); #2;
        fair_limit = '0;
        start_agent(6, 6);
        start_agent(7, 1);
        expect_tenure(6, 6, "R8");
        expect_tenure(7, 1, "R4");
        wait_quiet();

        // R10: host wins a free bus and ignores the limit
        @(posedge clk); #2;
        fair_limit = 8'd2;
        host_rem = 3;
        start_agent(0, 2);
        expect_tenure(HOST, 3, "R10");
        expect_tenure(0, 2, "R4");
        wait_quiet();

        // R11: host arriving mid-tenure forces the agent off after the limit
        @(posedge clk); #2;
        start_agent(5, 4);
        expect_tenure(5, 2, "R11");
        expect_tenure(HOST, 3, "R10");
        expect_tenure(5, 2, "R5");
        do begin
            @(negedge clk); #1;
        end while (!agent_gnt[5]);
        @(posedge clk); #2;
        host_rem = 3;
        wait_quiet();

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule